// File: doc/BRIEF.md
# Lockable General-Purpose Pin Bank

This block manages nine general-purpose pins through a small word-addressed register interface. Each pin can be an input or an output. Input pins pass through a two-stage synchronizer and an optional invert stage. Software then reads the result either as the live level or as a sticky event. The event is captured only when a rising level stays high across three consecutive slow RTC samples. Software clears the event by writing 1 to it.

Set input data bits whose routing bit is enabled are combined into one system-management interrupt request. Output pins can be made to drive low while the core power-good input is low. This lets a pin in an always-on domain face logic that loses power. A set-only lock bit freezes every configuration register. Only reset releases it.

Top module: `gpio_bank`

## Requirements
- R1: After reset the registers read: direction 0x1FF (all inputs), invert 0, routing 0, event-mode 0, power-loss forcing 0, pull-up 0x3FF, lock 0. The data register then reads the synchronized, inverted pin levels.
- R2: Register word addresses are 0 direction (bit=1 input), 1 invert, 2 data, 3 routing, 4 event-mode, 5 power-loss forcing, 6 pull-up, 7 lock (bit 0). A write to a configuration register is visible on the read port the next cycle. Bits above 8 read 0, except pull-up, which holds bits 9:0.
- R3: For an input pin with event-mode off, data bit i reads pinIn[i] XOR invert[i], two clock cycles after the pin changes. Writes to that bit have no effect.
- R4: smiReq is 1 exactly when some pin is an input, has its routing bit set and reads 1 in the data register.
- R5: For an input pin with event-mode on, the data bit becomes 1 on the third consecutive high RTC sample (rtcTick cycles) of the inverted level, provided a low sample came before them.
- R6: An event-mode data bit stays 1 when the level falls. A data write with a 1 in that position clears it. If a set and a clear arrive in the same cycle, the set wins.
- R7: A high level lasting only one or two RTC samples never sets an event-mode data bit.
- R8: For an output pin (direction 0), pinOe is 1 and pinOut follows the written data bit. pinOut is forced to 0 while pwrOk is low if the pin's forcing bit is 1.
- R9: Once the lock is 1, writes to direction, invert, routing, event-mode, forcing and pull-up registers are ignored. Data writes still take effect. pullEn always mirrors the pull-up register.
- R10: The lock bit is set by writing 1 to bit 0 at address 7. Writing 0 does not clear it; only reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rtcTick | input | 1 | One-cycle enable marking each slow RTC sample |
| pwrOk | input | 1 | Core power-good; low means core power lost |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word address for read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr, combinational |
| pinIn | input | 9 | Raw pin levels from the pads |
| pinOut | output | 9 | Output values to the pads |
| pinOe | output | 9 | Output enables, 1 for output pins |
| pullEn | output | 10 | Pull-up enables to the pads |
| smiReq | output | 1 | Combined interrupt request |

## Verification
The checker assumes rtcTick is a single-cycle pulse that arrives no faster than every few clocks. It also assumes pwrOk and pinIn may change in any cycle but are stable around the clock edge, and that reset is asserted once at time zero, before any lock. The bench drives every input one time unit after the rising edge and generates rtcTick from a counter every fourth cycle. A mid-run reset is only applied while the checker's disable condition holds. In the random phase the bench keeps the lock register out of the address mix so that configuration keeps changing.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PIN_N  = 9;
  localparam int PULL_N = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR   = 3'd0,
    REG_INV   = 3'd1,
    REG_DATA  = 3'd2,
    REG_ROUTE = 3'd3,
    REG_PULSE = 3'd4,
    REG_CORE  = 3'd5,
    REG_PULL  = 3'd6,
    REG_LOCK  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic [PIN_N-1:0]  dirIn;
    logic [PIN_N-1:0]  inv;
    logic [PIN_N-1:0]  route;
    logic [PIN_N-1:0]  pulse;
    logic [PIN_N-1:0]  core;
    logic [PULL_N-1:0] pull;
  } cfg_t;

  typedef struct packed {
    logic             dataWr;
    logic [PIN_N-1:0] dataVal;
  } strobe_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output cfg_t              cfgQ,
  output logic              lockQ,
  output strobe_t           strb
);
  logic cfgWr;
  logic unusedHiBits;

  assign unusedHiBits = ^wrData[DATA_W-1:PULL_N];
  assign cfgWr        = wrEn & ~lockQ;

  always_comb begin
    strb.dataWr  = wrEn && (regSel_e'(addr) == REG_DATA);
    strb.dataVal = wrData[PIN_N-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ.dirIn <= '1;
      cfgQ.inv   <= '0;
      cfgQ.route <= '0;
      cfgQ.pulse <= '0;
      cfgQ.core  <= '0;
      cfgQ.pull  <= '1;
      lockQ      <= 1'b0;
    end else begin
      if (cfgWr) begin
        case (regSel_e'(addr))
          REG_DIR:   cfgQ.dirIn <= wrData[PIN_N-1:0];
          REG_INV:   cfgQ.inv   <= wrData[PIN_N-1:0];
          REG_ROUTE: cfgQ.route <= wrData[PIN_N-1:0];
          REG_PULSE: cfgQ.pulse <= wrData[PIN_N-1:0];
          REG_CORE:  cfgQ.core  <= wrData[PIN_N-1:0];
          REG_PULL:  cfgQ.pull  <= wrData[PULL_N-1:0];
          default:   ;
        endcase
      end
      if (wrEn && (regSel_e'(addr) == REG_LOCK) && wrData[0]) begin
        lockQ <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_TICKS  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rtcTick,
  input  logic              pwrOk,
  input  logic [PIN_N-1:0]  pinIn,
  input  cfg_t              cfg,
  input  logic              lockQ,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rdData,
  output logic [PIN_N-1:0]  pinOut,
  output logic [PIN_N-1:0]  pinOe,
  output logic [PULL_N-1:0] pullEn,
  output logic              smiReq
);
  localparam int CNT_W = $clog2(QUAL_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(QUAL_TICKS - 1);

  logic [PIN_N-1:0] syncQ [SYNC_STAGES];
  logic [PIN_N-1:0] level;
  logic [PIN_N-1:0] evt;
  logic [PIN_N-1:0] pulseIn;
  logic [PIN_N-1:0] clrMask;
  logic [PIN_N-1:0] latchQ;
  logic [PIN_N-1:0] outQ;
  logic [PIN_N-1:0] dataView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  assign level = syncQ[SYNC_STAGES-1] ^ cfg.inv;

  for (genvar p = 0; p < PIN_N; p++) begin : g_pin
    logic [CNT_W-1:0] hiCnt;
    logic             armed;

    assign evt[p] = rtcTick & level[p] & armed & (hiCnt == LAST_CNT);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hiCnt <= '0;
        armed <= 1'b0;
      end else if (rtcTick) begin
        if (!level[p]) begin
          hiCnt <= '0;
          armed <= 1'b1;
        end else if (armed) begin
          if (evt[p]) armed <= 1'b0;
          else        hiCnt <= hiCnt + 1'b1;
        end
      end
    end
  end

  assign pulseIn = cfg.dirIn & cfg.pulse;
  assign clrMask = {PIN_N{strb.dataWr}} & strb.dataVal & pulseIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      outQ   <= '0;
    end else begin
      latchQ <= (latchQ & ~clrMask) | (evt & pulseIn);
      if (strb.dataWr) outQ <= (outQ & cfg.dirIn) | (strb.dataVal & ~cfg.dirIn);
    end
  end

  assign dataView = (~cfg.dirIn & outQ)
                  | (cfg.dirIn & ~cfg.pulse & level)
                  | (pulseIn & latchQ);

  assign pinOut = outQ & ~(cfg.core & {PIN_N{~pwrOk}});
  assign pinOe  = ~cfg.dirIn;
  assign pullEn = cfg.pull;
  assign smiReq = |(dataView & cfg.route & cfg.dirIn);

  always_comb begin
    rdData = '0;
    case (regSel_e'(addr))
      REG_DIR:   rdData[PIN_N-1:0]  = cfg.dirIn;
      REG_INV:   rdData[PIN_N-1:0]  = cfg.inv;
      REG_DATA:  rdData[PIN_N-1:0]  = dataView;
      REG_ROUTE: rdData[PIN_N-1:0]  = cfg.route;
      REG_PULSE: rdData[PIN_N-1:0]  = cfg.pulse;
      REG_CORE:  rdData[PIN_N-1:0]  = cfg.core;
      REG_PULL:  rdData[PULL_N-1:0] = cfg.pull;
      REG_LOCK:  rdData[0]          = lockQ;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_TICKS  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rtcTick,
  input  logic              pwrOk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [PIN_N-1:0]  pinIn,
  output logic [PIN_N-1:0]  pinOut,
  output logic [PIN_N-1:0]  pinOe,
  output logic [PULL_N-1:0] pullEn,
  output logic              smiReq
);
  cfg_t    cfgQ;
  logic    lockQ;
  strobe_t strb;

  gpio_ctrl ctrlI (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .cfgQ   (cfgQ),
    .lockQ  (lockQ),
    .strb   (strb)
  );

  gpio_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .QUAL_TICKS  (QUAL_TICKS)
  ) dpI (
    .clk     (clk),
    .rstN    (rstN),
    .rtcTick (rtcTick),
    .pwrOk   (pwrOk),
    .pinIn   (pinIn),
    .cfg     (cfgQ),
    .lockQ   (lockQ),
    .strb    (strb),
    .addr    (addr),
    .rdData  (rdData),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .pullEn  (pullEn),
    .smiReq  (smiReq)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              pwrOk,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [PIN_N-1:0]  wrLo,
  input logic [DATA_W-1:0] rdData,
  input cfg_t              cfg,
  input logic              lockQ,
  input logic [PIN_N-1:0]  pinOut,
  input logic [PULL_N-1:0] pullEn,
  input logic              smiReq
);
  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> $stable(cfg));

  // R9
  pull_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> $stable(pullEn));

  // R4
  smi_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    smiReq |-> ((cfg.route & cfg.dirIn) != '0));

  // R8
  core_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pwrOk |-> ((pinOut & cfg.core & ~cfg.dirIn) == '0));

  // R2
  route_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !lockQ && regSel_e'(addr) == REG_ROUTE) |=> (cfg.route == $past(wrLo)));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:PULL_N] == '0);
endmodule

bind gpio_bank gpio_bank_chk chkI (
  .clk    (clk),
  .rstN   (rstN),
  .pwrOk  (pwrOk),
  .wrEn   (wrEn),
  .addr   (addr),
  .wrLo   (wrData[gpio_pkg::PIN_N-1:0]),
  .rdData (rdData),
  .cfg    (cfgQ),
  .lockQ  (lockQ),
  .pinOut (pinOut),
  .pullEn (pullEn),
  .smiReq (smiReq)
);

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rtcTick = 1'b0;
  logic        pwrOk = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wrData = 32'd0;
  logic [8:0]  pinIn = 9'd0;
  logic [31:0] rdData;
  logic [8:0]  pinOut, pinOe;
  logic [9:0]  pullEn;
  logic        smiReq;

  int checkCnt = 0;
  int failCnt = 0;
  int tickCnt = 0;
  int cycCnt = 0;
  bit done = 0;

  gpio_bank dut_i (
    .clk(clk), .rstN(rstN), .rtcTick(rtcTick), .pwrOk(pwrOk),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .pullEn(pullEn),
    .smiReq(smiReq)
  );

  always #5 clk = ~clk;

  // reference model state
  bit [8:0] mDir, mInv, mRoute, mPulse, mCore, mOut, mLatch, mS1, mS2;
  bit [9:0] mPull;
  bit       mLock;
  int       mHist[9];

  task automatic mReset();
    mDir = '1; mInv = '0; mRoute = '0; mPulse = '0; mCore = '0;
    mOut = '0; mLatch = '0; mS1 = '0; mS2 = '0; mPull = '1; mLock = 0;
    for (int i = 0; i < 9; i++) mHist[i] = 15;
  endtask

  function automatic bit [8:0] mView();
    bit [8:0] v;
    for (int i = 0; i < 9; i++) begin
      if (!mDir[i])       v[i] = mOut[i];
      else if (mPulse[i]) v[i] = mLatch[i];
      else                v[i] = mS2[i] ^ mInv[i];
    end
    return v;
  endfunction

  function automatic bit [31:0] mRead(bit [2:0] a);
    case (a)
      3'd0: return {23'd0, mDir};
      3'd1: return {23'd0, mInv};
      3'd2: return {23'd0, mView()};
      3'd3: return {23'd0, mRoute};
      3'd4: return {23'd0, mPulse};
      3'd5: return {23'd0, mCore};
      3'd6: return {22'd0, mPull};
      default: return {31'd0, mLock};
    endcase
  endfunction

  initial mReset();

  always @(posedge clk) begin
    if (!rstN) mReset();
    else begin
      for (int i = 0; i < 9; i++) begin
        bit lv;
        bit setv;
        lv = mS2[i] ^ mInv[i];
        setv = 0;
        if (rtcTick) begin
          mHist[i] = ((mHist[i] << 1) | int'(lv)) & 15;
          if (mHist[i] == 7 && mDir[i] && mPulse[i]) setv = 1;
        end
        if (wrEn && addr == 3'd2) begin
          if (mDir[i] && mPulse[i] && wrData[i]) mLatch[i] = 0;
          if (!mDir[i]) mOut[i] = wrData[i];
        end
        if (setv) mLatch[i] = 1;
      end
      mS2 = mS1;
      mS1 = pinIn;
      if (wrEn && !mLock) begin
        case (addr)
          3'd0: mDir   = wrData[8:0];
          3'd1: mInv   = wrData[8:0];
          3'd3: mRoute = wrData[8:0];
          3'd4: mPulse = wrData[8:0];
          3'd5: mCore  = wrData[8:0];
          3'd6: mPull  = wrData[9:0];
          default: ;
        endcase
      end
      if (wrEn && addr == 3'd7 && wrData[0]) mLock = 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit [8:0] v;
      bit [8:0] po;
      v = mView();
      for (int i = 0; i < 9; i++) po[i] = mOut[i] & ~(mCore[i] & ~pwrOk);
      chk(addr == 3'd2 ? "R3 data" : (addr == 3'd7 ? "R10 lock" : "R2 readback"),
          rdData, mRead(addr));
      chk("R8 pinOut", {23'd0, pinOut}, {23'd0, po});
      chk("R8 pinOe", {23'd0, pinOe}, {23'd0, ~mDir});
      chk("R9 pullEn", {22'd0, pullEn}, {22'd0, mPull});
      chk("R4 smiReq", {31'd0, smiReq}, {31'd0, |(v & mRoute & mDir)});
    end
  end

  always @(posedge clk) begin
    #1;
    tickCnt++;
    rtcTick = (tickCnt % 4 == 0);
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(bit [2:0] a, bit [31:0] d);
    @(posedge clk); #1;
    wrEn = 1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 0;
  endtask

  task automatic expReg(string tag, bit [2:0] a, bit [31:0] e);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    chk(tag, rdData, e);
  endtask

  task automatic expBit(string tag, int b, bit e);
    @(posedge clk); #1;
    addr = 3'd2;
    @(negedge clk);
    chk(tag, {31'd0, rdData[b]}, {31'd0, e});
  endtask

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  always @(posedge clk) begin
    cycCnt++;
    if (cycCnt > 150000 && !done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rstN = 1;
    idle(4);
    // R1 reset values
    expReg("R1 dir", 3'd0, 32'h1FF);
    expReg("R1 inv", 3'd1, 32'h0);
    expReg("R1 data", 3'd2, 32'h0);
    expReg("R1 route", 3'd3, 32'h0);
    expReg("R1 pulse", 3'd4, 32'h0);
    expReg("R1 core", 3'd5, 32'h0);
    expReg("R1 pull", 3'd6, 32'h3FF);
    expReg("R1 lock", 3'd7, 32'h0);
    // R2 writes and reserved bits
    wr(3'd1, 32'h0A5);
    expReg("R2 inv", 3'd1, 32'h0A5);
    wr(3'd3, 32'hFFFF_FFFF);
    expReg("R2 route reserved", 3'd3, 32'h1FF);
    wr(3'd6, 32'hFFFF_F2AA);
    expReg("R2 pull", 3'd6, 32'h2AA);
    wr(3'd6, 32'h3FF);
    // R3 live input path with invert
    pinIn = 9'h003;
    idle(3);
    expReg("R3 level", 3'd2, 32'h0A6);
    wr(3'd2, 32'h1FF);
    expReg("R3 write ignored", 3'd2, 32'h0A6);
    // R4 combined request
    @(negedge clk); chk("R4 smi high", {31'd0, smiReq}, 32'd1);
    pinIn = 9'h0A5;
    idle(3);
    @(negedge clk); chk("R4 smi low", {31'd0, smiReq}, 32'd0);
    // R5 event capture on pin 1
    wr(3'd1, 32'h0);
    pinIn = 9'h000;
    wr(3'd4, 32'h002);
    idle(16);
    expBit("R5 idle low", 1, 0);
    pinIn = 9'h002;
    idle(20);
    expBit("R5 event set", 1, 1);
    // R6 sticky and write-one-to-clear
    pinIn = 9'h000;
    idle(16);
    expBit("R6 holds after fall", 1, 1);
    wr(3'd2, 32'h002);
    expBit("R6 cleared", 1, 0);
    // R7 short high rejected
    pinIn = 9'h002;
    idle(5);
    pinIn = 9'h000;
    idle(16);
    expBit("R7 short pulse", 1, 0);
    // R6 set wins: hold clear writes across the qualifying sample
    pinIn = 9'h002;
    for (int k = 0; k < 24; k++) begin
      @(posedge clk); #1;
      wrEn = 1; addr = 3'd2; wrData = 32'h002;
    end
    @(posedge clk); #1; wrEn = 0;
    pinIn = 9'h000;
    idle(8);
    // R8 outputs and power-loss forcing
    wr(3'd0, 32'h1F0);
    wr(3'd2, 32'h00F);
    @(negedge clk); chk("R8 drive", {23'd0, pinOut[3:0]}, 32'hF);
    wr(3'd5, 32'h003);
    @(posedge clk); #1; pwrOk = 0;
    @(negedge clk); chk("R8 forced", {28'd0, pinOut[3:0]}, 32'hC);
    @(posedge clk); #1; pwrOk = 1;
    @(negedge clk); chk("R8 released", {28'd0, pinOut[3:0]}, 32'hF);
    // random phase with model compare
    for (int k = 0; k < 3000; k++) begin
      @(posedge clk); #1;
      pinIn = 9'($urandom);
      pwrOk = ($urandom % 8) != 0;
      wrEn = ($urandom % 3) == 0;
      addr = 3'($urandom % 7);
      wrData = $urandom;
    end
    @(posedge clk); #1; wrEn = 0;
    // R9 lock freezes configuration
    wr(3'd0, 32'h1F0);
    wr(3'd4, 32'h001);
    wr(3'd6, 32'h3FF);
    wr(3'd7, 32'h1);
    wr(3'd4, 32'h1FF);
    expReg("R9 pulse frozen", 3'd4, 32'h001);
    wr(3'd6, 32'h0);
    @(negedge clk); chk("R9 pull frozen", {22'd0, pullEn}, 32'h3FF);
    wr(3'd0, 32'h0);
    expReg("R9 dir frozen", 3'd0, 32'h1F0);
    @(posedge clk); #1; pwrOk = 1;
    wr(3'd2, 32'h005);
    @(negedge clk); chk("R9 data writable", {28'd0, pinOut[3:0]}, 32'h5);
    // R10 lock cannot be cleared
    wr(3'd7, 32'h0);
    expReg("R10 sticky", 3'd7, 32'h1);
    idle(4);
    finishRun();
  end
endmodule